// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for clause 22 management transactions on a two-wire MDC/MDIO link to an external PHY. Software writes a PHY address and a register number into the address register. A write transaction starts when software loads the write-data register. A read transaction starts when software changes the read bit of the command register from 0 to 1.

While a transaction runs, the indicator register shows a busy flag. A read also sets a separate not-valid flag, which stays set until the returned data is in the status register. Software polls until both flags are clear before it uses the read data. A reset bit in the configuration register aborts any transaction and holds the block idle until software writes the normal configuration value back.

MDC is generated only while a frame is on the wire and idles low. Its period is set by a divide field in the configuration register.

Top module: `mdio_host`

## Requirements
- R1: After synchronous reset, the indicator register (offset 5; bit 0 busy, bit 1 not-valid) reads 0, the configuration register (offset 0) reads the default divide of 8 with the reset bit (bit 31) clear, MDC is low and MDIO is not driven.
- R2: Writing the data register (offset 3) while idle starts a 64-bit write frame, sent MSB first with MDIO driven for every bit. The frame is 32 ones, start 01, opcode 01, PHY address (address register bits 12:8), register number (address register bits 4:0), turnaround 10, then the 16 data bits. The PHY samples each bit on the rising edge of MDC.
- R3: A read starts only when bit 0 of the command register (offset 1) goes from 0 to 1 while the block is idle. Writing 1 again without first writing 0 starts nothing.
- R4: A read frame carries opcode 10. The block drives the 46 bits up to and including the register number, then releases MDIO for the turnaround and data bits. It samples 16 data bits, MSB first, on the MDC rising edges of bits 48 to 63, and places them in the status register (offset 4).
- R5: The busy bit is set from the cycle after the starting write until the frame ends, and each frame has exactly 64 MDC rising edges.
- R6: The not-valid bit is set together with busy when a read starts. It clears in the same cycle as busy, which is the cycle the status register receives the read data.
- R7: Setting configuration bit 31 aborts any frame within two cycles: busy and not-valid clear, MDC goes low and MDIO is released. No frame can start until bit 31 is written back to 0.
- R8: The MDC period equals configuration bits 7:0 in system clocks, and values below 4 act as 4. Within each period MDC is low for floor(div/2) cycles and high for the rest.
- R9: Writes to the address or data register while busy is set are ignored. They start no frame and leave the register readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A bit index that drifts inside the frame engine shows at the MDIO pins within one MDC period, as a wrong driven bit or an output enable that drops at the wrong place. The bench checks both against its own frame model at every rising edge of MDC. A bad divider count shows as a wrong MDC period or high time on the first bit. A lost busy or not-valid flag shows on the next indicator poll, either as a frame that keeps running after the flags read idle or as a status value read before the last data bit was sampled.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int REG_AW = 3;
  localparam int BUS_W  = 32;

  localparam logic [REG_AW-1:0] OFS_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CMD  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_ADDR = 3'd2;
  localparam logic [REG_AW-1:0] OFS_DATA = 3'd3;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd4;
  localparam logic [REG_AW-1:0] OFS_IND  = 3'd5;

  localparam int CFG_RST_BIT  = 31;
  localparam int IND_BUSY_BIT = 0;
  localparam int IND_NV_BIT   = 1;

  localparam logic [1:0] FR_SOF   = 2'b01;
  localparam logic [1:0] FR_OP_WR = 2'b01;
  localparam logic [1:0] FR_OP_RD = 2'b10;
  localparam logic [1:0] FR_TA_WR = 2'b10;
endpackage

// File: rtl/mdc_gen.sv
`timescale 1ns/1ps
module mdc_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             mdc,
  output logic             rise,
  output logic             bit_end
);
  logic [DIV_W-1:0] div_eff, half, cnt, cnt_nx;

  always_comb begin
    div_eff = (div_cfg < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_cfg;
    half    = div_eff >> 1;
    cnt_nx  = cnt + DIV_W'(1);
    rise    = run && (cnt_nx == half);
    bit_end = run && (cnt == div_eff - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (bit_end) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      mdc <= (cnt_nx >= half);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc) else $error("mdc high while idle"); // R8
  AST_MDC_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |=> !mdc) else $error("mdc low phase too short"); // R8
  AST_MDC_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |=> mdc) else $error("mdc high phase too short"); // R8
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        start_wr,
  input  logic        start_rd,
  input  logic [4:0]  phy_ad,
  input  logic [4:0]  reg_ad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        bit_end,
  input  logic        mdio_i,
  output logic        busy,
  output logic        rd_mode,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 14;
  localparam int DATA_POS  = PRE_LEN + 16;
  localparam int LAST      = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] frame_nx, shreg;
  logic [IDX_W-1:0]     idx, idx_nx;

  always_comb begin
    frame_nx = {{PRE_LEN{1'b1}}, FR_SOF,
                start_rd ? FR_OP_RD : FR_OP_WR,
                phy_ad, reg_ad,
                start_rd ? 2'b11 : FR_TA_WR,
                start_rd ? 16'hFFFF : wdata};
    idx_nx   = idx + IDX_W'(1);
    done     = busy && bit_end && (idx == IDX_W'(LAST));
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      rd_mode <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!busy && (start_wr || start_rd)) begin
      busy    <= 1'b1;
      rd_mode <= start_rd;
      idx     <= '0;
      mdio_o  <= frame_nx[LAST];
      shreg   <= frame_nx << 1;
      mdio_oe <= 1'b1;
    end else if (busy && bit_end) begin
      if (idx == IDX_W'(LAST)) begin
        busy    <= 1'b0;
        rd_mode <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else begin
        idx     <= idx_nx;
        mdio_o  <= shreg[LAST];
        shreg   <= shreg << 1;
        mdio_oe <= !(rd_mode && (idx_nx >= IDX_W'(TA_POS)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (busy && rd_mode && rise && (idx >= IDX_W'(DATA_POS)))
      rdata <= {rdata[14:0], mdio_i};
  end

  AST_TA_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_mode && (idx >= IDX_W'(TA_POS))) |-> !mdio_oe) else $error("mdio driven in read tail"); // R4
  AST_HEAD_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (busy && (idx < IDX_W'(TA_POS))) |-> mdio_oe) else $error("mdio released in frame head"); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe) else $error("mdio driven while idle"); // R7
endmodule

// File: rtl/mdio_host.sv
`timescale 1ns/1ps
module mdio_host
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 8,
  parameter int MIN_DIV   = 4,
  parameter int PRE_LEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             cfg_rst_q, cmd_q, nv_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      data_q, stat_q, eng_rdata;
  logic             eng_busy, eng_rd, eng_done;
  logic             mdc_rise, mdc_bit_end;
  logic             start_wr, start_rd;
  logic [BUS_W-1:0] rd_mux;
  logic             unused_bits;

  assign unused_bits = ^wr_data[30:16];

  always_comb begin
    start_wr = wr_en && (wr_addr == OFS_DATA) && !eng_busy && !cfg_rst_q;
    start_rd = wr_en && (wr_addr == OFS_CMD) && wr_data[0] && !cmd_q
               && !eng_busy && !cfg_rst_q;
  end

  mdc_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(eng_busy), .div_cfg(cfg_div_q),
    .mdc(mdc), .rise(mdc_rise), .bit_end(mdc_bit_end)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst(rst), .abort(cfg_rst_q),
    .start_wr(start_wr), .start_rd(start_rd),
    .phy_ad(phy_q), .reg_ad(reg_q), .wdata(wr_data[15:0]),
    .rise(mdc_rise), .bit_end(mdc_bit_end), .mdio_i(mdio_i),
    .busy(eng_busy), .rd_mode(eng_rd), .done(eng_done), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rst_q <= 1'b0;
      cfg_div_q <= DIV_W'(DIV_RESET);
      cmd_q     <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      data_q    <= '0;
      stat_q    <= '0;
      nv_q      <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == OFS_CFG)) begin
        cfg_rst_q <= wr_data[CFG_RST_BIT];
        cfg_div_q <= wr_data[DIV_W-1:0];
      end
      if (wr_en && (wr_addr == OFS_CMD))
        cmd_q <= wr_data[0];
      if (wr_en && (wr_addr == OFS_ADDR) && !eng_busy) begin
        phy_q <= wr_data[12:8];
        reg_q <= wr_data[4:0];
      end
      if (wr_en && (wr_addr == OFS_DATA) && !eng_busy)
        data_q <= wr_data[15:0];
      if (cfg_rst_q)
        nv_q <= 1'b0;
      else if (start_rd)
        nv_q <= 1'b1;
      else if (eng_done && eng_rd)
        nv_q <= 1'b0;
      if (eng_done && eng_rd)
        stat_q <= eng_rdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      OFS_CFG: begin
        rd_mux[CFG_RST_BIT] = cfg_rst_q;
        rd_mux[DIV_W-1:0]   = cfg_div_q;
      end
      OFS_CMD:  rd_mux[0]     = cmd_q;
      OFS_ADDR: begin
        rd_mux[12:8] = phy_q;
        rd_mux[4:0]  = reg_q;
      end
      OFS_DATA: rd_mux[15:0] = data_q;
      OFS_STAT: rd_mux[15:0] = stat_q;
      OFS_IND: begin
        rd_mux[IND_BUSY_BIT] = eng_busy;
        rd_mux[IND_NV_BIT]   = nv_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && wr_en && (wr_addr == OFS_ADDR)) |=> $stable({phy_q, reg_q})) else $error("address changed while busy"); // R9
  AST_NV_ON_START: assert property (@(posedge clk) disable iff (rst)
    start_rd |=> (nv_q && eng_busy)) else $error("read start flags missing"); // R6
  AST_NV_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    nv_q |-> eng_busy) else $error("not-valid without busy"); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cfg_rst_q |=> !eng_busy) else $error("busy during reset bit"); // R7
endmodule

// File: tb/mdio_host_test.sv
`timescale 1ns/1ps
module mdio_host_test;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_host uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  int          rises = 0;
  int          rd_base = 0;
  logic [15:0] phy_resp = '0;
  logic        cap_o  [0:255];
  logic        cap_oe [0:255];
  time         rise_t [0:255];
  time         last_rise = 0;
  time         hi_len = 0;

  // PHY-side model: records each rising edge, presents read data for the next bit
  always @(posedge mdc) begin
    int k;
    cap_o[rises % 256]  = mdio_o;
    cap_oe[rises % 256] = mdio_oe;
    rise_t[rises % 256] = $time;
    last_rise = $time;
    k = rises - rd_base + 1;
    mdio_i <= (k >= 48 && k <= 63) ? phy_resp[63 - k] : 1'b1;
    rises = rises + 1;
  end

  always @(negedge mdc) hi_len = $time - last_rise;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(OFS_IND, v);
      if (v[0] == 1'b0) return;
    end
    check(1'b0, "R5 busy never cleared", v, 32'h0);
  endtask

  task automatic idle_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  task automatic check_frame(input int base, input logic [63:0] f, input bit rd,
                             input string tag);
    int bad = 0;
    for (int k = 0; k < 64; k++) begin
      bit eoe = !(rd && k >= 46);
      if (cap_oe[(base + k) % 256] !== eoe) bad++;
      else if (eoe && cap_o[(base + k) % 256] !== f[63 - k]) bad++;
    end
    check(bad == 0, tag, 32'(bad), 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(OFS_IND, v);
    check(v == 32'h0, "R1 indicator after reset", v, 32'h0);
    bus_rd(OFS_CFG, v);
    check(v == 32'h8, "R1 config after reset", v, 32'h8);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {30'b0, mdc, mdio_oe}, 32'h0);
  endtask

  task automatic t_write_and_busy_ignore();
    logic [31:0] v;
    int base;
    bus_wr(OFS_CFG, 32'd4);
    bus_wr(OFS_ADDR, 32'h0000_150A);
    base = rises;
    bus_wr(OFS_DATA, 32'h0000_BEEF);
    bus_rd(OFS_IND, v);
    check(v == 32'h1, "R5 busy after write start", v, 32'h1);
    bus_wr(OFS_ADDR, 32'h0000_0303);   // R9 ignored while busy
    bus_wr(OFS_DATA, 32'h0000_1234);   // R9 ignored while busy
    wait_idle();
    idle_clks(40);
    check(rises - base == 64, "R5 R9 one frame of 64 edges", 32'(rises - base), 32'd64);
    check_frame(base, exp_frame(1'b0, 5'h15, 5'h0A, 16'hBEEF), 1'b0, "R2 write frame bits");
    check(32'(rise_t[(base + 1) % 256] - rise_t[base % 256]) == 32'd16,
          "R8 period div4", 32'(rise_t[(base + 1) % 256] - rise_t[base % 256]), 32'd16);
    bus_rd(OFS_ADDR, v);
    check(v == 32'h0000_150A, "R9 address kept", v, 32'h0000_150A);
    bus_rd(OFS_DATA, v);
    check(v == 32'h0000_BEEF, "R9 data kept", v, 32'h0000_BEEF);
  endtask

  task automatic t_read(input logic [7:0] div, input logic [15:0] resp,
                        input logic [4:0] p, input logic [4:0] r, input int per_ns,
                        input int hi_ns);
    logic [31:0] v;
    int base;
    bus_wr(OFS_CFG, {24'b0, div});
    bus_wr(OFS_ADDR, {19'b0, p, 3'b0, r});
    bus_wr(OFS_CMD, 32'h0);
    phy_resp = resp;
    rd_base = rises;
    base = rises;
    bus_wr(OFS_CMD, 32'h1);
    bus_rd(OFS_IND, v);
    check(v == 32'h3, "R3 R6 busy and not-valid at read start", v, 32'h3);
    wait_idle();
    bus_rd(OFS_IND, v);
    check(v == 32'h0, "R6 not-valid clear with busy", v, 32'h0);
    bus_rd(OFS_STAT, v);
    check(v == {16'h0, resp}, "R4 read data", v, {16'h0, resp});
    check_frame(base, exp_frame(1'b1, p, r, 16'h0), 1'b1, "R4 read frame and release");
    check(32'(rise_t[(base + 1) % 256] - rise_t[base % 256]) == 32'(per_ns),
          "R8 period", 32'(rise_t[(base + 1) % 256] - rise_t[base % 256]), 32'(per_ns));
    check(32'(hi_len) == 32'(hi_ns), "R8 high time", 32'(hi_len), 32'(hi_ns));
  endtask

  task automatic t_no_edge();
    logic [31:0] v;
    int r0 = rises;
    bus_wr(OFS_CMD, 32'h1);
    idle_clks(20);
    bus_rd(OFS_IND, v);
    check(v == 32'h0 && rises == r0, "R3 repeated one starts nothing", v, 32'h0);
  endtask

  task automatic t_clamp();
    int base;
    bus_wr(OFS_CFG, 32'd2);
    base = rises;
    bus_wr(OFS_DATA, 32'h0000_0001);
    wait_idle();
    idle_clks(10);
    check(32'(rise_t[(base + 1) % 256] - rise_t[base % 256]) == 32'd16,
          "R8 divide below 4 clamps", 32'(rise_t[(base + 1) % 256] - rise_t[base % 256]), 32'd16);
    check(32'(hi_len) == 32'd8, "R8 clamp high time", 32'(hi_len), 32'd8);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int r0;
    bus_wr(OFS_CFG, 32'd6);
    bus_wr(OFS_CMD, 32'h0);
    rd_base = rises;
    bus_wr(OFS_CMD, 32'h1);
    idle_clks(100);
    bus_wr(OFS_CFG, 32'h8000_0006);
    idle_clks(3);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 pins idle after abort",
          {30'b0, mdc, mdio_oe}, 32'h0);
    bus_rd(OFS_IND, v);
    check(v == 32'h0, "R7 flags clear after abort", v, 32'h0);
    r0 = rises;
    bus_wr(OFS_DATA, 32'h0000_7777);
    idle_clks(60);
    bus_rd(OFS_IND, v);
    check(v == 32'h0 && rises == r0, "R7 no start while reset bit set", v, 32'h0);
    bus_wr(OFS_CFG, 32'd4);
    bus_wr(OFS_DATA, 32'h0000_55AA);
    bus_rd(OFS_IND, v);
    check(v == 32'h1, "R7 start after release", v, 32'h1);
    wait_idle();
  endtask

  initial begin
    idle_clks(5);
    rst = 1'b0;
    idle_clks(2);
    t_reset();
    t_write_and_busy_ignore();
    t_read(8'd6, 16'hA5C3, 5'h03, 5'h11, 24, 12);
    t_no_edge();
    t_read(8'd7, 16'h0F0F, 5'h1F, 5'h00, 28, 16);
    t_clamp();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule